// File: doc/BRIEF.md
# PCM Serial Codec Port

This block is the digital serial port of a telephony voice codec. Each 8 kHz frame it moves one transmit sample out and one receive sample in over a three-wire serial link. The link has an external bit clock, a frame sync and a data line in each direction. Samples are either 8-bit companded words (mu-law or A-law, with no arithmetic done here) or 16-bit linear words. A mode input picks the word size. The codec core sees the port through parallel sample registers: a transmit word that is taken at every sync, and a receive word with a one-cycle valid strobe.

All logic runs on a free-running reference clock. The bit clock, frame sync and serial input are synchronised into that clock and turned into edge pulses. The port tracks frame lock by measuring the spacing of sync rising edges in reference cycles. It watches both the sync and the bit clock for a stuck level and then raises a partial power-down request toward the codec. While lock is missing or the global power-down input is set, the serial output is held high.

Top module: `pcm_port`

## Requirements
- R1: Words are sent and received MSB first. The first bit is launched on the first bit-clock rising edge after a frame-sync rising edge. Each received bit is taken from `sdin` on the bit-clock falling edge that follows its launch.
- R2: With `linear_mode`=0 the word is 8 bits. `tx_sample[7:0]` is sent, and the received byte lands in `rx_sample[7:0]` with `rx_sample[15:8]`=0.
- R3: With `linear_mode`=1 the word is 16 bits. All of `tx_sample` is sent, and all 16 received bits land in `rx_sample`.
- R4: `rx_valid` is high for exactly one reference cycle per received word, after the word's last bit. `rx_sample` already holds the new word in that cycle.
- R5: `locked` rises only on a sync rising edge that completes two consecutive sync intervals. Each of those intervals must lie within `FRAME_CYC`±`FRAME_TOL` reference cycles. Three syncs are needed from a cold start.
- R6: `locked` falls when a sync interval lies outside that window. It also falls when no sync rising edge arrives for 2×`FRAME_CYC` reference cycles.
- R7: In the cycle after any cycle with `locked`=0 or `pwrdn`=1, `sdout` is 1. `sdout` is also 1 outside a word's bit slots.
- R8: `pd_req` is asserted when `fsync` shows no edge for 2×`FRAME_CYC` reference cycles, whether it is stuck high or stuck low.
- R9: `pd_req` is asserted when `bclk` shows no edge for `BCLK_STALL_CYC` reference cycles. It stays low while both inputs toggle normally.
- R10: `pwrdn`=1 overrides everything. From the next cycle `locked`=0, `pd_req`=1, `sdout`=1, and no `rx_valid` is produced.
- R11: `tx_sample` and `linear_mode` are captured at the sync rising edge. A change during the word does not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn | input | 1 | Global power-down, overrides all state |
| linear_mode | input | 1 | 1 = 16-bit linear word, 0 = 8-bit companded word |
| bclk | input | 1 | External serial bit clock |
| fsync | input | 1 | External frame sync, nominal 8 kHz |
| sdin | input | 1 | Serial receive data |
| tx_sample | input | 16 | Parallel transmit word from codec core |
| sdout | output | 1 | Serial transmit data |
| rx_sample | output | 16 | Parallel received word |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_sample` |
| locked | output | 1 | Frame lock status |
| pd_req | output | 1 | Partial power-down request |

## Verification
The bound checker examines four behaviours in every cycle: the forced-high output whenever lock is missing or power-down is set, the single-cycle width of the receive strobe, the override applied by power-down, and the rule that lock may only appear on a sync edge. Bit ordering, the two word lengths, capture of the transmit word at sync, and the exact number of good intervals needed for lock can only be shown by the bench driving whole frames. The same holds for the window violation that drops lock and for the stuck-sync and stalled-clock timeouts. Each of those runs for hundreds of reference cycles and is compared against a word or flag the bench computes itself.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int SAMPLE_W = 16;
  localparam int COMP_W   = 8;

  typedef logic [SAMPLE_W-1:0] sample_t;

  typedef enum logic {
    MODE_COMPANDED = 1'b0,
    MODE_LINEAR    = 1'b1
  } word_mode_e;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], din[i]};
    end
    assign lvl[i]  = sh[STAGES-1];
    assign rise[i] = sh[STAGES-1] & ~sh[STAGES];
    assign fall[i] = ~sh[STAGES-1] & sh[STAGES];
  end
endmodule

// File: rtl/pcm_lock_mon.sv
module pcm_lock_mon #(
  parameter int FRAME_CYC      = 6250,
  parameter int FRAME_TOL      = 64,
  parameter int BCLK_STALL_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrdn,
  input  logic fs_rise,
  input  logic fs_edge,
  input  logic bclk_edge,
  output logic locked,
  output logic pd_req
);
  localparam int GAP_MAX = 2 * FRAME_CYC;
  localparam int GW      = $clog2(GAP_MAX + 1);
  localparam int SW      = $clog2(BCLK_STALL_CYC + 1);
  localparam logic [GW-1:0] GAP_TOP = GW'(GAP_MAX);
  localparam logic [GW-1:0] WIN_LO  = GW'(FRAME_CYC - FRAME_TOL - 1);
  localparam logic [GW-1:0] WIN_HI  = GW'(FRAME_CYC + FRAME_TOL - 1);
  localparam logic [SW-1:0] ST_TOP  = SW'(BCLK_STALL_CYC);

  logic [GW-1:0] gap_q, idle_q;
  logic [SW-1:0] stall_q;
  logic [1:0]    good_q, good_n;
  logic          in_win;

  assign in_win = (gap_q >= WIN_LO) && (gap_q <= WIN_HI);

  always_comb begin
    good_n = good_q;
    if (fs_rise)               good_n = in_win ? ((good_q == 2'd2) ? 2'd2 : good_q + 2'd1) : 2'd0;
    else if (gap_q == GAP_TOP) good_n = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst || pwrdn) begin
      gap_q   <= '0;
      idle_q  <= '0;
      stall_q <= '0;
      good_q  <= '0;
      locked  <= 1'b0;
      pd_req  <= pwrdn;
    end else begin
      if (fs_rise)                gap_q <= '0;
      else if (gap_q != GAP_TOP)  gap_q <= gap_q + 1'b1;
      if (fs_edge)                idle_q <= '0;
      else if (idle_q != GAP_TOP) idle_q <= idle_q + 1'b1;
      if (bclk_edge)              stall_q <= '0;
      else if (stall_q != ST_TOP) stall_q <= stall_q + 1'b1;
      good_q <= good_n;
      locked <= (good_n == 2'd2);
      pd_req <= (idle_q == GAP_TOP) || (stall_q == ST_TOP);
    end
  end
endmodule

// File: rtl/pcm_shifter.sv
module pcm_shifter
  import pcm_pkg::*;
#(
  parameter int SAMPLE_BITS = SAMPLE_W,
  parameter int COMP_BITS   = COMP_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwrdn,
  input  logic                   lin_mode,
  input  logic [SAMPLE_BITS-1:0] tx_sample,
  input  logic                   fs_rise,
  input  logic                   bclk_rise,
  input  logic                   bclk_fall,
  input  logic                   sdin_s,
  input  logic                   locked,
  output logic                   sdout,
  output logic [SAMPLE_BITS-1:0] rx_sample,
  output logic                   rx_valid
);
  localparam int CW = $clog2(SAMPLE_BITS + 1);
  localparam int PAD = SAMPLE_BITS - COMP_BITS;
  localparam logic [CW-1:0] LEN_LIN = CW'(SAMPLE_BITS);
  localparam logic [CW-1:0] LEN_CMP = CW'(COMP_BITS);

  logic [SAMPLE_BITS-1:0] txsr, rxsr, rx_shift;
  logic [CW-1:0]          tx_left, rx_left;
  logic                   lin_q, bit_q;

  assign rx_shift = {rxsr[SAMPLE_BITS-2:0], sdin_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      txsr <= '0; rxsr <= '0; tx_left <= '0; rx_left <= '0;
      lin_q <= MODE_COMPANDED; bit_q <= 1'b1; rx_valid <= 1'b0; rx_sample <= '0;
    end else if (pwrdn) begin
      tx_left <= '0; rx_left <= '0; bit_q <= 1'b1; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fs_rise) begin
        lin_q   <= lin_mode;
        txsr    <= lin_mode ? tx_sample : {tx_sample[COMP_BITS-1:0], {PAD{1'b0}}};
        tx_left <= lin_mode ? LEN_LIN : LEN_CMP;
        rx_left <= lin_mode ? LEN_LIN : LEN_CMP;
        rxsr    <= '0;
        bit_q   <= 1'b1;
      end else begin
        if (bclk_rise) begin
          if (tx_left != '0) begin
            bit_q   <= txsr[SAMPLE_BITS-1];
            txsr    <= txsr << 1;
            tx_left <= tx_left - 1'b1;
          end else begin
            bit_q <= 1'b1;
          end
        end
        if (bclk_fall && (rx_left > tx_left)) begin
          rxsr    <= rx_shift;
          rx_left <= rx_left - 1'b1;
          if (rx_left == CW'(1)) begin
            rx_valid  <= 1'b1;
            rx_sample <= lin_q ? rx_shift : {{PAD{1'b0}}, rx_shift[COMP_BITS-1:0]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  sdout <= 1'b1;
    else if (pwrdn || !locked) sdout <= 1'b1;
    else                      sdout <= bit_q;
  end
endmodule

// File: rtl/pcm_port.sv
module pcm_port
  import pcm_pkg::*;
#(
  parameter int FRAME_CYC      = 6250,
  parameter int FRAME_TOL      = 64,
  parameter int BCLK_STALL_CYC = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pwrdn,
  input  logic                linear_mode,
  input  logic                bclk,
  input  logic                fsync,
  input  logic                sdin,
  input  logic [SAMPLE_W-1:0] tx_sample,
  output logic                sdout,
  output logic [SAMPLE_W-1:0] rx_sample,
  output logic                rx_valid,
  output logic                locked,
  output logic                pd_req
);
  logic [1:0] lvl, rise, fall;
  logic       fs_rise, fs_edge, bclk_rise, bclk_fall;
  logic       sd_m, sd_s;

  pcm_edge_sync #(.N(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din({fsync, bclk}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign bclk_rise = rise[0];
  assign bclk_fall = fall[0];
  assign fs_rise   = rise[1];
  assign fs_edge   = rise[1] | fall[1];

  always_ff @(posedge clk) begin
    if (rst) begin sd_m <= 1'b0; sd_s <= 1'b0; end
    else     begin sd_m <= sdin; sd_s <= sd_m; end
  end

  pcm_lock_mon #(
    .FRAME_CYC(FRAME_CYC), .FRAME_TOL(FRAME_TOL), .BCLK_STALL_CYC(BCLK_STALL_CYC)
  ) u_lock (
    .clk(clk), .rst(rst), .pwrdn(pwrdn), .fs_rise(fs_rise), .fs_edge(fs_edge),
    .bclk_edge(bclk_rise | bclk_fall), .locked(locked), .pd_req(pd_req)
  );

  pcm_shifter #(.SAMPLE_BITS(SAMPLE_W), .COMP_BITS(COMP_W)) u_shift (
    .clk(clk), .rst(rst), .pwrdn(pwrdn), .lin_mode(linear_mode), .tx_sample(tx_sample),
    .fs_rise(fs_rise), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .sdin_s(sd_s),
    .locked(locked), .sdout(sdout), .rx_sample(rx_sample), .rx_valid(rx_valid)
  );

  wire unused_lvl = &{1'b0, lvl};
endmodule

// File: rtl/pcm_port_chk.sv
module pcm_port_chk (
  input logic clk,
  input logic rst,
  input logic pwrdn,
  input logic locked,
  input logic sdout,
  input logic rx_valid,
  input logic pd_req,
  input logic fs_rise
);
  assert_sdout_safe_R7: assert property (@(posedge clk) disable iff (rst)
    (!locked || pwrdn) |=> sdout);

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_pwrdn_override_R10: assert property (@(posedge clk) disable iff (rst)
    pwrdn |=> (!locked && pd_req && !rx_valid));

  assert_lock_on_sync_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(fs_rise));
endmodule

bind pcm_port pcm_port_chk u_chk (
  .clk(clk), .rst(rst), .pwrdn(pwrdn), .locked(locked), .sdout(sdout),
  .rx_valid(rx_valid), .pd_req(pd_req), .fs_rise(fs_rise)
);

// File: tb/test_pcm_port.sv
module test_pcm_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwrdn = 1'b0;
  logic        linear_mode = 1'b0;
  logic        bclk = 1'b0;
  logic        fsync = 1'b0;
  logic        sdin = 1'b0;
  logic [15:0] tx_sample = '0;
  logic        sdout, rx_valid, locked, pd_req;
  logic [15:0] rx_sample;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  logic [15:0] vword = '0;

  always #10 clk = ~clk;

  pcm_port #(.FRAME_CYC(320), .FRAME_TOL(8), .BCLK_STALL_CYC(64)) i_pcm_port (
    .clk(clk), .rst(rst), .pwrdn(pwrdn), .linear_mode(linear_mode), .bclk(bclk),
    .fsync(fsync), .sdin(sdin), .tx_sample(tx_sample), .sdout(sdout),
    .rx_sample(rx_sample), .rx_valid(rx_valid), .locked(locked), .pd_req(pd_req)
  );

  always @(negedge clk) if (!rst && rx_valid) begin vcount++; vword = rx_sample; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one frame of nper bit periods (10 clk each); returns bits seen on sdout
  task automatic frame(input int nper, input logic lin, input logic [15:0] txw,
                       input logic [15:0] rxw, input logic swap_tx, output logic [15:0] got);
    int w = lin ? 16 : 8;
    got = '0;
    linear_mode = lin;
    tx_sample = txw;
    for (int p = 0; p < nper; p++) begin
      @(negedge clk);
      bclk = 1'b1;
      sdin = (p >= 1 && p <= w) ? rxw[w-p] : 1'b0;
      if (swap_tx && p == 3) begin tx_sample = ~txw; linear_mode = ~lin; end
      repeat (5) @(negedge clk);
      if (p >= 1 && p <= w) got = {got[14:0], sdout};
      bclk = 1'b0;
      if (p == 0) fsync = 1'b1;
      if (p == 1) fsync = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic idle_bclk(input int n, input logic fs_level);
    fsync = fs_level;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bclk = 1'b1;
      repeat (4) @(negedge clk); bclk = 1'b0;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic relock();
    logic [15:0] g;
    for (int i = 0; i < 3; i++) frame(32, 1'b0, 16'h0, 16'h0, 1'b0, g);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R7 reset sdout", sdout, 1);
    check("R5 reset locked", locked, 0);
    check("R4 reset rx_valid", rx_valid, 0);
    check("R9 reset pd_req", pd_req, 0);
  endtask

  task automatic t_lock();
    logic [15:0] g;
    frame(32, 1'b0, 16'h0, 16'h0, 1'b0, g);
    frame(32, 1'b0, 16'h0, 16'h0, 1'b0, g);
    check("R5 one interval not enough", locked, 0);
    check("R7 unlocked frame sdout high", g, 16'h00FF);
    frame(32, 1'b0, 16'h0, 16'h0, 1'b0, g);
    check("R5 locked after two intervals", locked, 1);
  endtask

  task automatic t_comp();
    logic [15:0] g;
    int v0 = vcount;
    frame(32, 1'b0, 16'h12A5, 16'h003C, 1'b0, g);
    check("R2 R1 companded tx bits", g[7:0], 8'hA5);
    check("R2 companded rx word", vword, 16'h003C);
    check("R4 one valid per word", vcount - v0, 1);
  endtask

  task automatic t_lin();
    logic [15:0] g;
    frame(32, 1'b1, 16'hC3E1, 16'h8001, 1'b0, g);
    check("R3 R1 linear tx bits", g, 16'hC3E1);
    check("R3 linear rx word", vword, 16'h8001);
    frame(32, 1'b1, 16'h5AA5, 16'h7F00, 1'b0, g);
    check("R3 linear tx pattern 2", g, 16'h5AA5);
    check("R3 linear rx pattern 2", vword, 16'h7F00);
  endtask

  task automatic t_txhold();
    logic [15:0] g;
    frame(32, 1'b1, 16'h1234, 16'hBEEF, 1'b1, g);
    check("R11 tx word held from sync", g, 16'h1234);
    check("R11 mode held from sync", vword, 16'hBEEF);
  endtask

  task automatic t_badspace();
    logic [15:0] g;
    frame(28, 1'b1, 16'h0F0F, 16'h0, 1'b0, g);
    frame(32, 1'b1, 16'h0F0F, 16'h0, 1'b0, g);
    check("R6 bad interval drops lock", locked, 0);
    check("R7 unlocked word forced high", g, 16'hFFFF);
    relock();
    check("R5 relock after bad interval", locked, 1);
  endtask

  task automatic t_fs_stuck();
    check("R8 no request while running", pd_req, 0);
    idle_bclk(80, 1'b0);
    check("R6 sync timeout drops lock", locked, 0);
    check("R8 sync stuck low request", pd_req, 1);
    check("R7 sdout high after loss", sdout, 1);
    relock();
    check("R8 request clears", pd_req, 0);
    idle_bclk(80, 1'b1);
    check("R8 sync stuck high request", pd_req, 1);
    fsync = 1'b0;
    relock();
  endtask

  task automatic t_bclk_stall();
    check("R9 no request with bclk running", pd_req, 0);
    repeat (40) @(negedge clk);
    check("R9 short gap no request", pd_req, 0);
    repeat (40) @(negedge clk);
    check("R9 bclk stall request", pd_req, 1);
    relock();
  endtask

  task automatic t_pwrdn();
    logic [15:0] g;
    int v0;
    check("R10 locked before power-down", locked, 1);
    @(negedge clk); pwrdn = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 pwrdn clears lock", locked, 0);
    check("R10 pwrdn requests", pd_req, 1);
    check("R10 pwrdn sdout", sdout, 1);
    v0 = vcount;
    frame(32, 1'b1, 16'h0000, 16'hA5A5, 1'b0, g);
    check("R10 no rx during pwrdn", vcount - v0, 0);
    check("R10 sdout held high", g, 16'hFFFF);
    pwrdn = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lock();
    t_comp();
    t_lin();
    t_txhold();
    t_badspace();
    t_fs_stuck();
    t_bclk_stall();
    t_pwrdn();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule